// File: doc/BRIEF.md
# 100BASE-TX Stream Delimiter Framer

This block sits between a nibble-wide MAC data path and the 5-bit code-group stream of a 100BASE-TX physical coding layer. On transmit it takes a nibble stream qualified by an enable and maps each nibble to a 5-bit code-group. The two nibbles of the opening preamble octet are overwritten, not preceded, by the start-of-stream pair J/K. The end-of-stream pair T/R is added after the final nibble. Between frames it sends IDLE code-groups.

On receive it watches the incoming code-groups for a J/K pair. It presents that pair to the MAC as two preamble nibbles, so the MAC sees the frame exactly as it was sent. It then decodes data code-groups and closes the frame on T/R. It reports invalid code-groups, false carriers and frames that stop without a proper end delimiter through an error output.

Both directions run on one nibble-rate clock. Scrambling, line coding and clock recovery belong to neighbouring blocks.

Top module: `pcs_delim_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tx_code is 11111, and rx_dv, rx_err and rx_nib are all zero.
- R2: While no frame is active and tx_en is low, tx_code is 11111 (IDLE) on every cycle, whatever tx_nib carries.
- R3: The cycle after tx_en is first sampled high in idle, tx_code is 11000 (J). The cycle after that, it is 10001 (K). These two code-groups stand in place of the first two nibbles of the frame.
- R4: Every later nibble sampled with tx_en high appears on tx_code one cycle later, mapped as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first cycle tx_en is sampled low in a frame yields 01101 (T), then 00111 (R), then IDLE. A tx_en sampled high while T or R is being produced does not start a frame. Only a tx_en sampled high in idle does.
- R6: A J code-group followed directly by K on rx_code yields two rx_dv cycles carrying preamble nibble 0101. They come two clock edges after J and K arrive.
- R7: Inside a frame, each valid data code-group is decoded by the R4 table. It appears on rx_nib with rx_dv high and rx_err low, two edges after arrival.
- R8: A T followed directly by R inside a frame ends it: rx_dv is low in the slot where T would be presented, and neither T nor R is presented.
- R9: A code-group inside a frame that is not in the R4 table is presented with rx_dv high, rx_err high and rx_nib 0000.
- R10: A J that is not followed by K is a false carrier. rx_err is high for one slot with rx_dv low, and no frame starts.
- R11: If IDLE arrives directly after an in-frame code-group, that last nibble is presented with rx_err high. rx_dv is low from the next slot.
- R12: Whenever rx_dv is low, rx_nib is 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | MAC transmit enable |
| tx_nib | input | 4 | MAC transmit nibble |
| tx_code | output | 5 | Transmit code-group |
| rx_code | input | 5 | Received code-group |
| rx_dv | output | 1 | Receive nibble valid to the MAC |
| rx_nib | output | 4 | Receive nibble to the MAC |
| rx_err | output | 1 | Receive error for the current slot |

## Verification
The assertions check the transmit delimiter ordering on every cycle: K always follows J, R always follows T, and an IDLE or R with tx_en low leads to IDLE. On the receive side they check that a frame always opens with a preamble nibble, that rx_dv drops right after an end pair, and that rx_nib is zero outside frames. The full 4B/5B mapping in both directions, the preamble replacement over many frame lengths, and the error cases (false carrier, invalid code-group, IDLE inside a frame) can only be shown by the bench. Its scenarios loop transmit back into receive, or drive code-group sequences directly.

// File: rtl/pcs_delim_pkg.sv
package pcs_delim_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [CG_W-1:0]  code_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam code_t CG_IDLE = 5'b11111;
  localparam code_t CG_J    = 5'b11000;
  localparam code_t CG_K    = 5'b10001;
  localparam code_t CG_T    = 5'b01101;
  localparam code_t CG_R    = 5'b00111;

  typedef struct packed {
    logic ok;
    nib_t nib;
  } dec_t;

  function automatic code_t enc_nib(input nib_t n);
    code_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic dec_t dec_code(input code_t c);
    dec_t d;
    d.ok = 1'b1;
    case (c)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.ok  = 1'b0;
        d.nib = '0;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
  import pcs_delim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  input  nib_t  tx_nib,
  output code_t tx_code
);
  typedef enum logic [1:0] {TS_IDLE, TS_K, TS_DATA, TS_R} tx_st_t;

  tx_st_t st_q, st_d;
  code_t  code_d;

  always_comb begin
    st_d   = st_q;
    code_d = CG_IDLE;
    case (st_q)
      TS_IDLE: begin
        if (tx_en) begin
          code_d = CG_J;
          st_d   = TS_K;
        end
      end
      TS_K: begin
        code_d = CG_K;
        st_d   = TS_DATA;
      end
      TS_DATA: begin
        if (tx_en) begin
          code_d = enc_nib(tx_nib);
        end else begin
          code_d = CG_T;
          st_d   = TS_R;
        end
      end
      default: begin
        code_d = CG_R;
        st_d   = TS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_IDLE;
      tx_code <= CG_IDLE;
    end else begin
      st_q    <= st_d;
      tx_code <= code_d;
    end
  end
endmodule

// File: rtl/pcs_rx_deframer.sv
module pcs_rx_deframer
  import pcs_delim_pkg::*;
#(
  parameter nib_t PRE_NIB = 4'h5
)(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t rx_code,
  output logic  rx_dv,
  output nib_t  rx_nib,
  output logic  rx_err,
  output logic  evt_start,
  output logic  evt_end
);
  typedef enum logic [1:0] {RS_HUNT, RS_SECOND, RS_FRAME} rx_st_t;

  rx_st_t st_q, st_d;
  code_t  prev_q;
  dec_t   dec_prev;
  logic   dv_d, err_d;
  nib_t   nib_d;
  logic   next_idle;

  assign dec_prev  = dec_code(prev_q);
  assign next_idle = (rx_code == CG_IDLE);
  assign evt_start = (st_q == RS_HUNT)  && (prev_q == CG_J) && (rx_code == CG_K);
  assign evt_end   = (st_q == RS_FRAME) && (prev_q == CG_T) && (rx_code == CG_R);

  always_comb begin
    st_d  = st_q;
    dv_d  = 1'b0;
    nib_d = '0;
    err_d = 1'b0;
    case (st_q)
      RS_HUNT: begin
        if (prev_q == CG_J) begin
          if (evt_start) begin
            dv_d  = 1'b1;
            nib_d = PRE_NIB;
            st_d  = RS_SECOND;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      RS_SECOND: begin
        dv_d  = 1'b1;
        nib_d = PRE_NIB;
        if (next_idle) begin
          err_d = 1'b1;
          st_d  = RS_HUNT;
        end else begin
          st_d  = RS_FRAME;
        end
      end
      default: begin
        if (evt_end) begin
          st_d = RS_HUNT;
        end else begin
          dv_d  = 1'b1;
          nib_d = dec_prev.ok ? dec_prev.nib : '0;
          err_d = ~dec_prev.ok;
          if (next_idle) begin
            err_d = 1'b1;
            st_d  = RS_HUNT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_HUNT;
      prev_q <= CG_IDLE;
      rx_dv  <= 1'b0;
      rx_nib <= '0;
      rx_err <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= rx_code;
      rx_dv  <= dv_d;
      rx_nib <= nib_d;
      rx_err <= err_d;
    end
  end
endmodule

// File: rtl/pcs_delim_framer.sv
module pcs_delim_framer
  import pcs_delim_pkg::*;
#(
  parameter logic [3:0] PRE_NIB = 4'h5
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic [3:0] tx_nib,
  output logic [4:0] tx_code,
  input  logic [4:0] rx_code,
  output logic       rx_dv,
  output logic [3:0] rx_nib,
  output logic       rx_err
);
  logic rx_evt_start;
  logic rx_evt_end;

  pcs_tx_framer u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_nib  (tx_nib),
    .tx_code (tx_code)
  );

  pcs_rx_deframer #(.PRE_NIB(PRE_NIB)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_code   (rx_code),
    .rx_dv     (rx_dv),
    .rx_nib    (rx_nib),
    .rx_err    (rx_err),
    .evt_start (rx_evt_start),
    .evt_end   (rx_evt_end)
  );
endmodule

// File: rtl/pcs_delim_framer_chk.sv
module pcs_delim_framer_chk #(
  parameter logic [3:0] PRE_NIB = 4'h5
)(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic [4:0] tx_code,
  input logic       rx_dv,
  input logic [3:0] rx_nib,
  input logic       rx_evt_start,
  input logic       rx_evt_end
);
  a_r2_idle_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_code == 5'b11111 || tx_code == 5'b00111) && !tx_en) |=> tx_code == 5'b11111);

  a_r3_k_after_j: assert property (@(posedge clk) disable iff (!rst_n)
    tx_code == 5'b11000 |=> tx_code == 5'b10001);

  a_r5_r_after_t: assert property (@(posedge clk) disable iff (!rst_n)
    tx_code == 5'b01101 |=> tx_code == 5'b00111);

  a_r5_idle_after_r: assert property (@(posedge clk) disable iff (!rst_n)
    tx_code == 5'b00111 |=> (tx_code == 5'b11111 || tx_code == 5'b11000));

  a_r6_opens_with_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> rx_nib == PRE_NIB);

  a_r6_start_event: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt_start |=> (rx_dv && rx_nib == PRE_NIB));

  a_r8_end_drops_dv: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt_end |=> !rx_dv);

  a_r12_nib_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> rx_nib == 4'h0);
endmodule

bind pcs_delim_framer pcs_delim_framer_chk #(.PRE_NIB(PRE_NIB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_en        (tx_en),
  .tx_code      (tx_code),
  .rx_dv        (rx_dv),
  .rx_nib       (rx_nib),
  .rx_evt_start (rx_evt_start),
  .rx_evt_end   (rx_evt_end)
);

// File: tb/pcs_delim_framer_tb.sv
module pcs_delim_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] C_I = 5'b11111, C_J = 5'b11000, C_K = 5'b10001,
                         C_T = 5'b01101, C_R = 5'b00111, C_H = 5'b00100;
  // 4B/5B table, entry F at the top, entry 0 at the bottom
  localparam logic [79:0] ENC_TAB = {5'b11101, 5'b11100, 5'b11011, 5'b11010,
                                     5'b10111, 5'b10110, 5'b10011, 5'b10010,
                                     5'b01111, 5'b01110, 5'b01011, 5'b01010,
                                     5'b10101, 5'b10100, 5'b01001, 5'b11110};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [4:0] tx_code;
  logic [4:0] rx_code = C_I;
  logic rx_dv, rx_err;
  logic [3:0] rx_nib;

  int n_chk = 0, n_bad = 0;
  bit done = 0, lb = 0;
  int n = 0;
  logic [4:0] txl [0:127];
  logic       dvl [0:127];
  logic [3:0] nbl [0:127];
  logic       erl [0:127];

  pcs_delim_framer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_nib(tx_nib), .tx_code(tx_code),
    .rx_code(rx_code), .rx_dv(rx_dv), .rx_nib(rx_nib), .rx_err(rx_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] benc(input logic [3:0] v);
    return ENC_TAB[v*5 +: 5];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    txl[n] = tx_code; dvl[n] = rx_dv; nbl[n] = rx_nib; erl[n] = rx_err;
    if (lb) rx_code = tx_code;
    n++;
  endtask

  task automatic chk_rx(input int i, input logic dv, input logic [3:0] nb,
                        input logic er, input string req);
    chk(dvl[i] == dv && nbl[i] == nb && erl[i] == er, req,
        {dvl[i], nbl[i], erl[i]}, {dv, nb, er});
  endtask

  task automatic loop_frame(input int len);
    logic [3:0] f [0:63];
    for (int k = 0; k < len; k++) f[k] = (k < 2) ? 4'h5 : 4'((k*5 + len*3) % 16);
    n = 0; lb = 1;
    for (int k = 0; k < len; k++) begin tx_en = 1; tx_nib = f[k]; step(); end
    tx_en = 0; tx_nib = 4'hF;
    for (int k = 0; k < 4; k++) step();
    chk(txl[0] == C_J, "R3 J", txl[0], C_J);
    chk(txl[1] == C_K, "R3 K", txl[1], C_K);
    for (int k = 2; k < len; k++) chk(txl[k] == benc(f[k]), "R4 encode", txl[k], benc(f[k]));
    chk(txl[len] == C_T, "R5 T", txl[len], C_T);
    chk(txl[len+1] == C_R, "R5 R", txl[len+1], C_R);
    chk(txl[len+2] == C_I, "R2 idle after frame", txl[len+2], C_I);
    chk_rx(1, 0, 0, 0, "R12 before frame");
    chk_rx(2, 1, 4'h5, 0, "R6 preamble first");
    chk_rx(3, 1, 4'h5, 0, "R6 preamble second");
    for (int k = 2; k < len; k++) chk_rx(k+2, 1, f[k], 0, "R7 decode");
    chk_rx(len+2, 0, 0, 0, "R8 end drops dv");
    chk_rx(len+3, 0, 0, 0, "R8 R not presented");
    lb = 0; rx_code = C_I;
    step(); step();
  endtask

  task automatic rx_direct(input logic [4:0] seq [0:9]);
    n = 0; lb = 0;
    for (int i = 0; i < 10; i++) begin rx_code = seq[i]; step(); end
    rx_code = C_I;
    step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] s [0:9];
    @(negedge clk);
    chk(tx_code == C_I && !rx_dv && !rx_err && rx_nib == 0, "R1 reset",
        {tx_code, rx_dv, rx_err, rx_nib}, {C_I, 6'b0});
    repeat (2) @(negedge clk);
    rst_n = 1;
    n = 0;
    step();
    chk(txl[0] == C_I && !dvl[0] && !erl[0] && nbl[0] == 0, "R1 after reset",
        {txl[0], dvl[0], erl[0], nbl[0]}, {C_I, 6'b0});

    // R2: idle with garbage on tx_nib
    n = 0;
    for (int v = 0; v < 16; v++) begin tx_nib = 4'(v); step(); end
    for (int v = 0; v < 16; v++) chk(txl[v] == C_I, "R2 idle ignores nibble", txl[v], C_I);
    for (int v = 0; v < 16; v++) chk_rx(v, 0, 0, 0, "R12 idle receive");

    // loopback sweep over frame lengths, covers every nibble value
    for (int len = 2; len < 22; len++) loop_frame(len);

    // R5: enable raised during T is not a start
    n = 0; lb = 0;
    for (int k = 0; k < 4; k++) begin tx_en = 1; tx_nib = 4'h5; step(); end
    tx_en = 0; step();
    tx_en = 1; tx_nib = 4'h5; step();
    step(); step();
    tx_en = 0; step(); step(); step();
    chk(txl[4] == C_T, "R5 T", txl[4], C_T);
    chk(txl[5] == C_R, "R5 enable during T/R ignored", txl[5], C_R);
    chk(txl[6] == C_J, "R5 restart from idle", txl[6], C_J);
    chk(txl[7] == C_K, "R3 K on restart", txl[7], C_K);

    // R10: false carrier, then a J J K start
    s = '{C_I, C_J, C_J, C_K, benc(4'h7), C_T, C_R, C_I, C_J, C_I};
    rx_direct(s);
    chk_rx(2, 0, 0, 1, "R10 false carrier");
    chk_rx(3, 1, 4'h5, 0, "R6 start after false J");
    chk_rx(4, 1, 4'h5, 0, "R6 second preamble");
    chk_rx(5, 1, 4'h7, 0, "R7 data");
    chk_rx(6, 0, 0, 0, "R8 end");
    chk_rx(9, 0, 0, 1, "R10 J then IDLE");
    chk_rx(10, 0, 0, 0, "R10 one slot only");

    // R9: invalid code-group inside a frame
    s = '{C_I, C_J, C_K, benc(4'h3), C_H, benc(4'h9), C_T, C_R, C_I, C_I};
    rx_direct(s);
    chk_rx(4, 1, 4'h3, 0, "R7 data before bad");
    chk_rx(5, 1, 4'h0, 1, "R9 invalid code");
    chk_rx(6, 1, 4'h9, 0, "R9 recovers");
    chk_rx(7, 0, 0, 0, "R8 end after bad");

    // R11: IDLE inside a frame
    s = '{C_I, C_J, C_K, benc(4'hA), benc(4'hB), C_I, C_I, C_I, C_I, C_I};
    rx_direct(s);
    chk_rx(4, 1, 4'hA, 0, "R11 earlier nibble clean");
    chk_rx(5, 1, 4'hB, 1, "R11 last nibble flagged");
    chk_rx(6, 0, 0, 0, "R11 dv drops");

    // R11: IDLE right after K
    s = '{C_I, C_J, C_K, C_I, C_I, C_I, C_I, C_I, C_I, C_I};
    rx_direct(s);
    chk_rx(2, 1, 4'h5, 0, "R6 first preamble");
    chk_rx(3, 1, 4'h5, 1, "R11 cut after K");
    chk_rx(4, 0, 0, 0, "R11 dv drops after K");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule